// File: doc/BRIEF.md
# Transmit Lane Distributor with Alignment Markers

This block sits on the transmit side of a multi-lane 40G or 100G Ethernet physical coding path, right after 64b/66b encoding. It takes one 66-bit block per accepted transfer: a 2-bit sync header and a 64-bit payload. It scrambles the payload with a self-synchronous scrambler and deals the resulting blocks in turn onto a parameterised number of virtual lanes. Four lanes is the 40G case. Twenty lanes is the 100G case, because twenty is the smallest count that divides evenly over both ten and four physical lanes.

Blocks are collected until every lane has one, and the whole lane group is then presented in parallel for a single cycle. At a fixed spacing the block inserts an alignment group, in which every lane carries its own identifying marker in the same cycle. Markers can fall in the middle of a packet, so a receiver must remove them before decoding. The input is held off for exactly the marker cycle, so no block is lost.

Top module: `lane_dist_tx`

## Requirements
- R1: The 64-bit payload is scrambled least-significant bit first. Each scrambled bit equals the input bit XOR the scrambled bits 39 and 58 positions earlier in the scrambled stream. The 2-bit header is not scrambled. Each lane word is `{header, scrambledPayload}`, with the header in bits [65:64].
- R2: After reset the scrambler history is the parameter `SCR_SEED` (default all ones, never zero). The history advances only when a block is accepted; idle cycles and marker cycles leave it unchanged.
- R3: Within a group, the k-th accepted block goes to lane k (lane l occupies `outLanes[l*66 +: 66]`). `outValid` pulses for one cycle, in the cycle after the last block of the group is accepted.
- R4: In a marker group, lane l carries the header 2'b10 and the payload `{4{~L, L}}`, where L is the 8-bit lane number.
- R5: The first group after reset is a marker group. After that, exactly `MARK_PERIOD-1` data groups are emitted between consecutive marker groups, so each lane carries one marker per `MARK_PERIOD` words.
- R6: `inReady` is low for exactly one cycle per marker group, namely the cycle before that marker appears. No accepted block is dropped or duplicated.
- R7: An incomplete group produces no output. `outValid` stays low for as long as fewer than `NUM_LANES` blocks of the group have been accepted, however long the input pauses.
- R8: While `rstN` is low, `outValid` and `inReady` are low. Reset discards any partial group and restarts the marker spacing and the scrambler.
- R9: `NUM_LANES` (at least 2) sets the lane count. With 20 lanes, each lane still carries its own marker pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input block present |
| inReady | output | 1 | Block accepted when high with inValid |
| inHeader | input | 2 | Sync header of the input block |
| inPayload | input | 64 | Unscrambled payload of the input block |
| outValid | output | 1 | Lane group valid for this cycle |
| outLanes | output | NUM_LANES*66 | One 66-bit word per lane, lane 0 in the low bits |

## Verification
The main instance is built with 4 lanes and a marker period of 4. With these values a marker group follows every three data groups, so marker insertion meeting back-to-back traffic, input stalls and a reset in the middle of a group all occur within a few dozen cycles rather than tens of thousands. A second instance with 20 lanes and a period of 2 checks the per-lane marker identities at the 100G width. Expected lane words come from a bit-serial scrambler model held in the bench.

// File: rtl/lane_dist_pkg.sv
package lane_dist_pkg;

  localparam int BLK_W = 66;
  localparam int PAY_W = 64;
  localparam int HDR_W = 2;
  localparam int SCR_W = 58;
  localparam int TAP_NEAR = 39;
  localparam logic [HDR_W-1:0] CTRL_HDR = 2'b10;

  // Strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic accept;      // a block is taken this cycle
    logic groupDone;   // the taken block completes a lane group
    logic insertMark;  // emit the marker group next cycle
  } ctrlStrobes_t;

  // Marker word for one lane: control header, lane id and its inverse repeated
  function automatic logic [BLK_W-1:0] markerWord(input int unsigned lane);
    logic [7:0] id;
    id = lane[7:0];
    return {CTRL_HDR, {4{~id, id}}};
  endfunction

endpackage

// File: rtl/lane_dist_scr.sv
module lane_dist_scr
  import lane_dist_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [PAY_W-1:0] dIn,
  output logic [PAY_W-1:0] dOut
);

  // history: bit SCR_W-1 is the newest scrambled bit, bit 0 the oldest
  logic [SCR_W-1:0] history;
  logic [SCR_W-1:0] historyNext;

  always_comb begin : scrMix
    logic [SCR_W-1:0] h;
    logic b;
    h = history;
    dOut = '0;
    for (int i = 0; i < PAY_W; i++) begin
      b = dIn[i] ^ h[SCR_W-TAP_NEAR] ^ h[0];
      dOut[i] = b;
      h = {b, h[SCR_W-1:1]};
    end
    historyNext = h;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) history <= SEED;
    else if (enable) history <= historyNext;
  end

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(history));

endmodule

// File: rtl/lane_dist_ctrl.sv
module lane_dist_ctrl
  import lane_dist_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int MARK_PERIOD = 16384,
  parameter int SLOT_W      = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  output ctrlStrobes_t      strb,
  output logic [SLOT_W-1:0] slot
);

  localparam int CNT_W = (MARK_PERIOD > 2) ? $clog2(MARK_PERIOD) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_LANES - 1);
  localparam logic [CNT_W-1:0]  LAST_GRP  = CNT_W'(MARK_PERIOD - 2);

  logic             markNeeded;
  logic [CNT_W-1:0] groupCnt;

  assign inReady         = !markNeeded;
  assign strb.accept     = inValid && !markNeeded;
  assign strb.groupDone  = strb.accept && (slot == LAST_SLOT);
  assign strb.insertMark = markNeeded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markNeeded <= 1'b1;
      groupCnt   <= '0;
      slot       <= '0;
    end else if (markNeeded) begin
      markNeeded <= 1'b0;
      groupCnt   <= '0;
    end else if (strb.accept) begin
      slot <= strb.groupDone ? '0 : slot + 1'b1;
      if (strb.groupDone) begin
        if (groupCnt == LAST_GRP) markNeeded <= 1'b1;
        else groupCnt <= groupCnt + 1'b1;
      end
    end
  end

  // R5
  period_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    groupCnt <= LAST_GRP);

  // R6
  single_mark_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    markNeeded |=> !markNeeded);

  // R5
  mark_at_group_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    markNeeded |-> slot == '0);

endmodule

// File: rtl/lane_dist_dp.sv
module lane_dist_dp
  import lane_dist_pkg::*;
#(
  parameter int               NUM_LANES = 4,
  parameter int               SLOT_W    = $clog2(NUM_LANES),
  parameter logic [SCR_W-1:0] SCR_SEED  = '1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [HDR_W-1:0]           inHeader,
  input  logic [PAY_W-1:0]           inPayload,
  input  ctrlStrobes_t               strb,
  input  logic [SLOT_W-1:0]          slot,
  output logic                       outValid,
  output logic [NUM_LANES*BLK_W-1:0] outLanes
);

  localparam int OUT_W = NUM_LANES * BLK_W;

  logic [PAY_W-1:0] scrPayload;
  logic [BLK_W-1:0] blkWord;
  logic [BLK_W-1:0] laneBuf [NUM_LANES-1];
  logic [OUT_W-1:0] gatherVec;
  logic [OUT_W-1:0] markVec;

  lane_dist_scr #(.SEED(SCR_SEED)) u_scr (
    .clk   (clk),
    .rstN  (rstN),
    .enable(strb.accept),
    .dIn   (inPayload),
    .dOut  (scrPayload)
  );

  assign blkWord = {inHeader, scrPayload};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign markVec[g*BLK_W +: BLK_W] = markerWord(g);
    if (g < NUM_LANES - 1) begin : g_buf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) laneBuf[g] <= '0;
        else if (strb.accept && slot == SLOT_W'(g)) laneBuf[g] <= blkWord;
      end
      assign gatherVec[g*BLK_W +: BLK_W] = laneBuf[g];
    end else begin : g_last
      assign gatherVec[g*BLK_W +: BLK_W] = blkWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLanes <= '0;
    end else if (strb.groupDone) begin
      outValid <= 1'b1;
      outLanes <= gatherVec;
    end else if (strb.insertMark) begin
      outValid <= 1'b1;
      outLanes <= markVec;
    end else begin
      outValid <= 1'b0;
    end
  end

  // R3
  out_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.groupDone || strb.insertMark));

  // R4
  marker_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.insertMark |=> outValid && outLanes[OUT_W-1 -: HDR_W] == CTRL_HDR);

  // R7
  no_partial_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.groupDone && !strb.insertMark |=> !outValid);

endmodule

// File: rtl/lane_dist_tx.sv
module lane_dist_tx
  import lane_dist_pkg::*;
#(
  parameter int          NUM_LANES   = 4,
  parameter int          MARK_PERIOD = 16384,
  parameter logic [57:0] SCR_SEED    = '1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [1:0]               inHeader,
  input  logic [63:0]              inPayload,
  output logic                     outValid,
  output logic [NUM_LANES*66-1:0]  outLanes
);

  localparam int SLOT_W = $clog2(NUM_LANES);

  ctrlStrobes_t      strb;
  logic [SLOT_W-1:0] slot;

  lane_dist_ctrl #(
    .NUM_LANES  (NUM_LANES),
    .MARK_PERIOD(MARK_PERIOD),
    .SLOT_W     (SLOT_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inReady(inReady),
    .strb   (strb),
    .slot   (slot)
  );

  lane_dist_dp #(
    .NUM_LANES(NUM_LANES),
    .SLOT_W   (SLOT_W),
    .SCR_SEED (SCR_SEED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inHeader (inHeader),
    .inPayload(inPayload),
    .strb     (strb),
    .slot     (slot),
    .outValid (outValid),
    .outLanes (outLanes)
  );

  // R6
  ready_vs_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> outValid && inReady);

endmodule

// File: tb/test_lane_dist_tx.sv
`timescale 1ns/1ps
module test_lane_dist_tx;

  localparam int LANES  = 4;
  localparam int PERIOD = 4;
  localparam int WIDE   = 20;

  // {idle cycles before, header, payload}
  localparam logic [69:0] VEC [12] = '{
    {4'd0, 2'b01, 64'h0000_0000_0000_0000},
    {4'd0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF},
    {4'd1, 2'b10, 64'h1E00_0000_0000_0000},
    {4'd0, 2'b01, 64'h0123_4567_89AB_CDEF},
    {4'd2, 2'b01, 64'h8000_0000_0000_0001},
    {4'd0, 2'b10, 64'h7800_0000_0000_00FF},
    {4'd0, 2'b01, 64'hA5A5_5A5A_C3C3_3C3C},
    {4'd3, 2'b01, 64'h0000_0001_0000_0000},
    {4'd0, 2'b01, 64'hDEAD_BEEF_CAFE_F00D},
    {4'd1, 2'b10, 64'hFF00_FF00_FF00_FF00},
    {4'd0, 2'b01, 64'h5555_5555_5555_5555},
    {4'd0, 2'b01, 64'h0F0F_0F0F_F0F0_F0F0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inHeader = '0;
  logic [63:0] inPayload = '0;
  logic inReady, outValid;
  logic [LANES*66-1:0] outLanes;
  logic inReadyW, outValidW;
  logic [WIDE*66-1:0] outLanesW;

  int checks = 0, fails = 0;
  int gIdx = 0, markerCnt = 0, notReady = 0, rxData = 0;
  logic [57:0] ms = '1;
  logic [65:0] expQ [$];

  always #2.5 clk = ~clk;

  lane_dist_tx #(.NUM_LANES(LANES), .MARK_PERIOD(PERIOD)) i_lane_dist_tx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inHeader(inHeader), .inPayload(inPayload),
    .outValid(outValid), .outLanes(outLanes));

  lane_dist_tx #(.NUM_LANES(WIDE), .MARK_PERIOD(2)) i_lane_dist_tx_wide (
    .clk(clk), .rstN(rstN), .inValid(1'b0), .inReady(inReadyW),
    .inHeader(2'b00), .inPayload(64'd0),
    .outValid(outValidW), .outLanes(outLanesW));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [65:0] mk(input int lane);
    logic [7:0] id;
    id = lane[7:0];
    return {2'b10, {4{~id, id}}};
  endfunction

  // bit-serial scrambler model: ms[0] newest, ms[k] is k+1 bits ago
  function automatic logic [63:0] scrModel(input logic [63:0] d);
    logic [63:0] r;
    logic b;
    for (int i = 0; i < 64; i++) begin
      b = d[i] ^ ms[38] ^ ms[57];
      ms = {ms[56:0], b};
      r[i] = b;
    end
    return r;
  endfunction

  task automatic sendBlock(input logic [1:0] h, input logic [63:0] p);
    inValid = 1'b1; inHeader = h; inPayload = p;
    while (!inReady) @(negedge clk);
    expQ.push_back({h, scrModel(p)});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin : monitor
    bit ok;
    logic [65:0] a, e, badA, badE;
    if (!rstN) gIdx = 0;
    else begin
      if (!inReady) notReady++;
      if (outValid) begin
        ok = 1'b1; badA = '0; badE = '0;
        if (gIdx % PERIOD == 0) begin
          markerCnt++;
          for (int l = 0; l < LANES; l++) begin
            a = outLanes[l*66 +: 66]; e = mk(l);
            if (a !== e && ok) begin ok = 1'b0; badA = a; badE = e; end
          end
          chk(ok, "R4 R5 marker group lane words", badA, badE);
        end else if (expQ.size() < LANES) begin
          chk(1'b0, "R6 data group without enough accepted blocks", expQ.size(), LANES);
        end else begin
          for (int l = 0; l < LANES; l++) begin
            a = outLanes[l*66 +: 66]; e = expQ.pop_front();
            if (a !== e && ok) begin ok = 1'b0; badA = a; badE = e; end
          end
          rxData += LANES;
          chk(ok, "R1 R3 scrambled data lane words", badA, badE);
        end
        gIdx++;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : mainSeq
    bit sawOut;
    logic [69:0] v;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R8 outValid during reset", outValid, 0);
    chk(inReady == 1'b0, "R8 inReady during reset", inReady, 0);
    chk(outValidW == 1'b0, "R8 wide outValid during reset", outValidW, 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b0, "R5 R6 ready held off before first marker", inReady, 0);
    chk(outValid == 1'b0, "R5 no output before first marker", outValid, 0);
    @(negedge clk);
    chk(inReady == 1'b1, "R6 ready returns after marker", inReady, 1);
    // R9 twenty lanes each carry their own marker
    begin : wideChk
      bit ok;
      ok = outValidW;
      for (int l = 0; l < WIDE; l++) if (outLanesW[l*66 +: 66] !== mk(l)) ok = 1'b0;
      chk(ok, "R9 R4 wide marker group", outLanesW[19*66 +: 66], mk(19));
    end

    // table walk: first pass with gaps, second pass back-to-back inverted
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 12; i++) begin
        v = VEC[i];
        if (pass == 0) idle(int'(v[69:66]));
        sendBlock(v[65:64], pass == 0 ? v[63:0] : ~v[63:0]);
      end
    end
    idle(4);
    chk(markerCnt == 3, "R5 marker groups after six data groups", markerCnt, 3);
    chk(rxData == 24 && expQ.size() == 0, "R6 every block emitted once", rxData, 24);
    chk(notReady == markerCnt, "R6 one stall cycle per marker", notReady, markerCnt);

    // R7 partial group stalls output
    sendBlock(2'b01, 64'h1111_2222_3333_4444);
    sendBlock(2'b01, 64'h5555_6666_7777_8888);
    sawOut = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (outValid) sawOut = 1'b1;
      @(negedge clk);
    end
    chk(!sawOut, "R7 no output on partial group", sawOut, 0);
    sendBlock(2'b10, 64'h9999_AAAA_BBBB_CCCC);
    sendBlock(2'b01, 64'hDDDD_EEEE_FFFF_0000);
    idle(3);
    chk(rxData == 28, "R3 R7 group completes after pause", rxData, 28);

    // R8 reset in the middle of a group, then scrambler restarts from seed
    sendBlock(2'b01, 64'h0BAD_0BAD_0BAD_0BAD);
    @(posedge clk); #1 rstN = 1'b0;
    expQ.delete();
    ms = '1;
    @(negedge clk);
    chk(outValid == 1'b0 && inReady == 1'b0, "R8 outputs low in mid-stream reset", {outValid, inReady}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    idle(2);
    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      sendBlock(v[65:64], v[63:0]);
    end
    idle(4);
    chk(rxData == 32 && expQ.size() == 0, "R2 R8 data after reset matches reseeded model", rxData, 32);
    chk(markerCnt == 4, "R5 R8 marker restarts after reset", markerCnt, 4);
    chk(notReady == markerCnt, "R6 stall cycles equal markers", notReady, markerCnt);

    summary();
    $finish;
  end

endmodule